// File: doc/BRIEF.md
# Message and Line Interrupt Collector

This block gathers two kinds of inbound interrupt events for a serial-link host port and turns them into per-source interrupt wires for a local interrupt controller. The first kind is a message-signalled interrupt: a write to a doorbell whose data word is a vector number. The second kind is four level-sensitive legacy lines (A to D). Each message vector is latched as a status bit. Each line level is tracked in a status bit. Software masks and unmasks each source and clears message status through a small register window.

There are 32 message vectors spread over 8 groups in interleaved order: vector v belongs to group v mod 8 and sits at bit v/8 of that group. Each group drives one interrupt wire and each legacy line drives one. A shared end-of-interrupt register lets software tell the block that a source was serviced. The wire of that source then drops for one cycle, so a downstream edge detector sees a new event if work is still pending. Address matching of the doorbell on the link and steering of interrupts to processors are done elsewhere.

Top module: `irq_collector`

## Requirements
- R1: A doorbell event (`msi_valid` high for one cycle) with vector v below 32 sets bit v/8 of group v mod 8. The bit is visible in the cycle after the event, in bits [3:0] of the group status register at 0x104 + 16*g.
- R2: A doorbell event with a vector of 32 or above changes no status bit in any group.
- R3: A register write to a group status register clears exactly the status bits whose data bits [3:0] are 1. Status bits whose data bits are 0 are left as they were.
- R4: When a doorbell event sets a bit in the same cycle that software clears that bit, the bit ends up set.
- R5: After reset all status and enable bits are 0. Writing 1s to bits [3:0] at 0x108 + 16*g sets the matching group enable bits. Writing 1s at 0x10C + 16*g clears them. Both addresses read back the enable bits in [3:0]. Clearing an enable bit keeps its status bit.
- R6: `msi_irq[g]` is high exactly when some status bit of group g is both set and enabled, except for the quiet cycle of R7.
- R7: Writing the value 4+g to the end-of-interrupt register at 0x050 forces `msi_irq[g]` low for the one cycle that follows the write. The output then returns high if enabled status is still set.
- R8: Line n's status (bit 0 at 0x184 + 16*n) equals `intx_in[n]` as it was one clock earlier, whether or not the line is enabled. Its enable bit is set by writing bit 0 = 1 at 0x188 + 16*n and cleared by writing bit 0 = 1 at 0x18C + 16*n. Both addresses read the enable bit in bit 0. `intx_irq[n]` is the status ANDed with the enable.
- R9: Writing the value n (0 to 3) to the end-of-interrupt register forces `intx_irq[n]` low for the one following cycle. Values of 12 and above change no output.
- R10: Reads of unmapped addresses and of the end-of-interrupt register return 0. Writes to unmapped addresses change no status or enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| msi_valid | input | 1 | One-cycle strobe for a doorbell write |
| msi_vector | input | 8 | Vector number carried by the doorbell write |
| intx_in | input | 4 | Legacy interrupt line levels, A to D |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| msi_irq | output | 8 | One interrupt wire per message group |
| intx_irq | output | 4 | One interrupt wire per legacy line |

## Verification
The assertions assume that a doorbell event and a register write can share a cycle. They also assume that a vector of any 8-bit value may arrive, and that `reg_addr` hits at most one register at a time. The stimulus makes every doorbell strobe one cycle wide and changes inputs only between clock edges. It deliberately combines a doorbell with a clear of the same bit, and it sends vectors above 31 whose low bits select groups that would otherwise stay empty. The bench's reference model keeps one pending flag and one enable flag per vector, not per group. Every clock it predicts both output buses from those flags.

// File: rtl/irq_agg_pkg.sv
`timescale 1ns/1ps
package irq_agg_pkg;

  // Register classes recognised by the address decoder
  typedef enum logic [2:0] {
    RK_NONE,
    RK_MSI_STAT,
    RK_MSI_ESET,
    RK_MSI_ECLR,
    RK_LINE_STAT,
    RK_LINE_ESET,
    RK_LINE_ECLR,
    RK_EOI
  } reg_kind_e;

  // Byte offsets of the three registers inside one 16-byte source slot
  localparam int SLOT_STATUS = 0;
  localparam int SLOT_ESET   = 4;
  localparam int SLOT_ECLR   = 8;

endpackage

// File: rtl/irq_reg_decode.sv
`timescale 1ns/1ps
module irq_reg_decode
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int GROUPS    = 8,
  parameter int LINES     = 4,
  parameter int MSI_BASE  = 'h104,
  parameter int LINE_BASE = 'h184,
  parameter int STRIDE    = 16,
  parameter int EOI_ADDR  = 'h050,
  parameter int IDX_W     = 3
) (
  input  logic [ADDR_W-1:0] addr_i,
  output reg_kind_e         kind_o,
  output logic [IDX_W-1:0]  idx_o
);

  always_comb begin
    kind_o = RK_NONE;
    idx_o  = '0;
    if (addr_i == ADDR_W'(EOI_ADDR)) kind_o = RK_EOI;
    for (int g = 0; g < GROUPS; g++) begin
      if (addr_i == ADDR_W'(MSI_BASE + STRIDE * g + SLOT_STATUS)) begin
        kind_o = RK_MSI_STAT;
        idx_o  = IDX_W'(g);
      end
      if (addr_i == ADDR_W'(MSI_BASE + STRIDE * g + SLOT_ESET)) begin
        kind_o = RK_MSI_ESET;
        idx_o  = IDX_W'(g);
      end
      if (addr_i == ADDR_W'(MSI_BASE + STRIDE * g + SLOT_ECLR)) begin
        kind_o = RK_MSI_ECLR;
        idx_o  = IDX_W'(g);
      end
    end
    for (int n = 0; n < LINES; n++) begin
      if (addr_i == ADDR_W'(LINE_BASE + STRIDE * n + SLOT_STATUS)) begin
        kind_o = RK_LINE_STAT;
        idx_o  = IDX_W'(n);
      end
      if (addr_i == ADDR_W'(LINE_BASE + STRIDE * n + SLOT_ESET)) begin
        kind_o = RK_LINE_ESET;
        idx_o  = IDX_W'(n);
      end
      if (addr_i == ADDR_W'(LINE_BASE + STRIDE * n + SLOT_ECLR)) begin
        kind_o = RK_LINE_ECLR;
        idx_o  = IDX_W'(n);
      end
    end
  end

endmodule

// File: rtl/msi_group_cell.sv
`timescale 1ns/1ps
module msi_group_cell #(
  parameter int GROUPS = 8,
  parameter int BITS   = 4,
  parameter int GROUP  = 0,
  parameter int VEC_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msi_valid_i,
  input  logic [VEC_W-1:0] msi_vector_i,
  input  logic             stat_clr_i,
  input  logic             en_set_i,
  input  logic             en_clr_i,
  input  logic             eoi_i,
  input  logic [BITS-1:0]  mask_i,
  output logic [BITS-1:0]  status_o,
  output logic [BITS-1:0]  enable_o,
  output logic             irq_o
);

  localparam int TOTAL = GROUPS * BITS;
  localparam int GSH   = $clog2(GROUPS);
  localparam int BSH   = $clog2(BITS);

  logic            in_range, hit;
  logic [BSH-1:0]  bit_of;
  logic [BITS-1:0] set_mask, clr_mask;
  logic [BITS-1:0] st_d, st_q, en_d, en_q;
  logic            st_ce, en_ce, mute_q;

  // Interleaved mapping: low bits pick the group, next bits pick the position
  assign in_range = {1'b0, msi_vector_i} < (VEC_W+1)'(TOTAL);
  assign bit_of   = msi_vector_i[GSH +: BSH];
  assign hit      = msi_valid_i && in_range && (msi_vector_i[GSH-1:0] == GSH'(GROUP));

  always_comb begin
    set_mask = '0;
    if (hit) set_mask[bit_of] = 1'b1;
    clr_mask = stat_clr_i ? mask_i : '0;
    // arrival is applied after the clear so a same-cycle event survives
    st_d  = (st_q & ~clr_mask) | set_mask;
    st_ce = hit | stat_clr_i;
    en_d  = (en_q | (en_set_i ? mask_i : '0)) & ~(en_clr_i ? mask_i : '0);
    en_ce = en_set_i | en_clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= '0;
      en_q   <= '0;
      mute_q <= 1'b0;
    end else begin
      if (st_ce) st_q <= st_d;
      if (en_ce) en_q <= en_d;
      mute_q <= eoi_i;
    end
  end

  assign status_o = st_q;
  assign enable_o = en_q;
  assign irq_o    = (|(st_q & en_q)) & ~mute_q;

  p_arrival_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> st_q[$past(bit_of)]);

  p_clear_takes_effect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_clr_i && !hit) |=> ((st_q & $past(mask_i)) == '0));

  p_arrival_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && stat_clr_i && mask_i[bit_of]) |=> st_q[$past(bit_of)]);

  p_eoi_quiet_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_i |=> !irq_o);

endmodule

// File: rtl/intx_line_cell.sv
`timescale 1ns/1ps
module intx_line_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  input  logic en_set_i,
  input  logic en_clr_i,
  input  logic eoi_i,
  output logic status_o,
  output logic enable_o,
  output logic irq_o
);

  logic st_q, en_q, en_d, en_ce, mute_q;

  always_comb begin
    en_ce = en_set_i | en_clr_i;
    en_d  = en_set_i & ~en_clr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= 1'b0;
      en_q   <= 1'b0;
      mute_q <= 1'b0;
    end else begin
      st_q <= line_i;
      if (en_ce) en_q <= en_d;
      mute_q <= eoi_i;
    end
  end

  assign status_o = st_q;
  assign enable_o = en_q;
  assign irq_o    = st_q & en_q & ~mute_q;

  p_line_eoi_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eoi_i |=> !irq_o);

  p_line_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr_i && !en_set_i) |=> !irq_o);

endmodule

// File: rtl/irq_collector.sv
`timescale 1ns/1ps
module irq_collector
  import irq_agg_pkg::*;
#(
  parameter int GROUPS    = 8,
  parameter int BITS      = 4,
  parameter int LINES     = 4,
  parameter int VEC_W     = 8,
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 32,
  parameter int MSI_BASE  = 'h104,
  parameter int LINE_BASE = 'h184,
  parameter int STRIDE    = 16,
  parameter int EOI_ADDR  = 'h050
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_valid,
  input  logic [VEC_W-1:0]  msi_vector,
  input  logic [LINES-1:0]  intx_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [GROUPS-1:0] msi_irq,
  output logic [LINES-1:0]  intx_irq
);

  localparam int IDX_W = $clog2(GROUPS > LINES ? GROUPS : LINES);
  localparam int TOTAL = GROUPS * BITS;

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  reg_kind_e         kind;
  logic [IDX_W-1:0]  idx;
  logic              eoi_wr;
  logic [GROUPS*BITS-1:0] msi_st_flat, msi_en_flat;
  logic [LINES-1:0]  line_st, line_en;

  irq_reg_decode #(
    .ADDR_W(ADDR_W), .GROUPS(GROUPS), .LINES(LINES), .MSI_BASE(MSI_BASE),
    .LINE_BASE(LINE_BASE), .STRIDE(STRIDE), .EOI_ADDR(EOI_ADDR), .IDX_W(IDX_W)
  ) u_decode (
    .addr_i(reg_addr),
    .kind_o(kind),
    .idx_o (idx)
  );

  assign eoi_wr = reg_we && (kind == RK_EOI);

  for (genvar gi = 0; gi < GROUPS; gi++) begin : g_group
    logic sel;
    assign sel = reg_we && (idx == IDX_W'(gi));
    msi_group_cell #(
      .GROUPS(GROUPS), .BITS(BITS), .GROUP(gi), .VEC_W(VEC_W)
    ) u_cell (
      .clk         (clk),
      .rst_n       (rst_core_n),
      .msi_valid_i (msi_valid),
      .msi_vector_i(msi_vector),
      .stat_clr_i  (sel && (kind == RK_MSI_STAT)),
      .en_set_i    (sel && (kind == RK_MSI_ESET)),
      .en_clr_i    (sel && (kind == RK_MSI_ECLR)),
      .eoi_i       (eoi_wr && (reg_wdata == DATA_W'(LINES + gi))),
      .mask_i      (reg_wdata[BITS-1:0]),
      .status_o    (msi_st_flat[gi*BITS +: BITS]),
      .enable_o    (msi_en_flat[gi*BITS +: BITS]),
      .irq_o       (msi_irq[gi])
    );
  end

  for (genvar ni = 0; ni < LINES; ni++) begin : g_line
    logic sel;
    assign sel = reg_we && (idx == IDX_W'(ni)) && reg_wdata[0];
    intx_line_cell u_line (
      .clk     (clk),
      .rst_n   (rst_core_n),
      .line_i  (intx_in[ni]),
      .en_set_i(sel && (kind == RK_LINE_ESET)),
      .en_clr_i(sel && (kind == RK_LINE_ECLR)),
      .eoi_i   (eoi_wr && (reg_wdata == DATA_W'(ni))),
      .status_o(line_st[ni]),
      .enable_o(line_en[ni]),
      .irq_o   (intx_irq[ni])
    );
  end

  // Read path
  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (idx == IDX_W'(g)) begin
        if (kind == RK_MSI_STAT)
          reg_rdata[BITS-1:0] = msi_st_flat[g*BITS +: BITS];
        if (kind == RK_MSI_ESET || kind == RK_MSI_ECLR)
          reg_rdata[BITS-1:0] = msi_en_flat[g*BITS +: BITS];
      end
    end
    for (int n = 0; n < LINES; n++) begin
      if (idx == IDX_W'(n)) begin
        if (kind == RK_LINE_STAT) reg_rdata[0] = line_st[n];
        if (kind == RK_LINE_ESET || kind == RK_LINE_ECLR) reg_rdata[0] = line_en[n];
      end
    end
  end

  logic vec_ok;
  assign vec_ok = {1'b0, msi_vector} < (VEC_W+1)'(TOTAL);

  p_far_vector_ignored_r2: assert property (@(posedge clk) disable iff (!rst_core_n)
    (msi_valid && !vec_ok && !(reg_we && kind == RK_MSI_STAT)) |=> $stable(msi_st_flat));

  p_stray_write_ignored_r10: assert property (@(posedge clk) disable iff (!rst_core_n)
    (reg_we && kind == RK_NONE && !msi_valid) |=> ($stable(msi_st_flat) && $stable(msi_en_flat) && $stable(line_en)));

endmodule

// File: tb/test_irq_collector.sv
`timescale 1ns/1ps
module test_irq_collector;

  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] EOI = 12'h050;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        msi_valid;
  logic [7:0]  msi_vector;
  logic [3:0]  intx_in;
  logic        reg_we;
  logic [11:0] reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic [7:0]  msi_irq;
  logic [3:0]  intx_irq;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_collector i_irq_collector (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_vector(msi_vector),
    .intx_in(intx_in), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .msi_irq(msi_irq), .intx_irq(intx_irq)
  );

  // Behavioural reference: one pending and one enable flag per vector
  bit pend [32];
  bit ven  [32];
  bit lst  [4];
  bit len  [4];
  bit gmute[8];
  bit lmute[4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int v = 0; v < 32; v++) begin pend[v] = 0; ven[v] = 0; end
      for (int g = 0; g < 8; g++) gmute[g] = 0;
      for (int n = 0; n < 4; n++) begin lst[n] = 0; len[n] = 0; lmute[n] = 0; end
    end else begin
      for (int g = 0; g < 8; g++) begin
        gmute[g] = reg_we && reg_addr == EOI && reg_wdata == 32'(4 + g);
        for (int p = 0; p < 4; p++) begin
          if (reg_we && reg_wdata[p]) begin
            if (reg_addr == 12'(32'h104 + 16*g)) pend[g + 8*p] = 0;
            if (reg_addr == 12'(32'h108 + 16*g)) ven[g + 8*p]  = 1;
            if (reg_addr == 12'(32'h10C + 16*g)) ven[g + 8*p]  = 0;
          end
        end
      end
      if (msi_valid && msi_vector < 8'd32) pend[msi_vector[4:0]] = 1;
      for (int n = 0; n < 4; n++) begin
        lmute[n] = reg_we && reg_addr == EOI && reg_wdata == 32'(n);
        lst[n]   = intx_in[n];
        if (reg_we && reg_wdata[0] && reg_addr == 12'(32'h188 + 16*n)) len[n] = 1;
        if (reg_we && reg_wdata[0] && reg_addr == 12'(32'h18C + 16*n)) len[n] = 0;
      end
    end
  end

  // Compare both output buses with the model on every clock
  always @(negedge clk) begin
    logic [7:0] em;
    logic [3:0] ei;
    if (rst_n && !done) begin
      for (int g = 0; g < 8; g++) begin
        em[g] = 1'b0;
        for (int p = 0; p < 4; p++) if (pend[g + 8*p] && ven[g + 8*p]) em[g] = 1'b1;
        if (gmute[g]) em[g] = 1'b0;
      end
      for (int n = 0; n < 4; n++) ei[n] = lst[n] && len[n] && !lmute[n];
      checks++;
      if (msi_irq !== em) begin
        errors++;
        $display("FAIL R6/R7 msi_irq at %0t actual=%h expected=%h", $time, msi_irq, em);
      end
      checks++;
      if (intx_irq !== ei) begin
        errors++;
        $display("FAIL R8/R9 intx_irq at %0t actual=%h expected=%h", $time, intx_irq, ei);
      end
    end
  end

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(posedge clk); #1;
    reg_we = 0; msi_valid = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d; msi_valid = 0;
  endtask

  task automatic msi(input logic [7:0] v);
    @(posedge clk); #1;
    reg_we = 0; msi_valid = 1; msi_vector = v;
  endtask

  task automatic wr_msi(input logic [11:0] a, input logic [31:0] d, input logic [7:0] v);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d; msi_valid = 1; msi_vector = v;
  endtask

  task automatic set_lines(input logic [3:0] v);
    @(posedge clk); #1;
    reg_we = 0; msi_valid = 0; intx_in = v;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(posedge clk); #1;
    reg_we = 0; msi_valid = 0; reg_addr = a;
    #2;
    check(reg_rdata, exp, tag);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 0; msi_valid = 0; msi_vector = '0; intx_in = '0;
    reg_we = 0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) idle();

    // R5 reset state
    rd(12'h104, 32'h0, "R5 group0 status after reset");
    rd(12'h108, 32'h0, "R5 group0 enable after reset");
    rd(12'h184, 32'h0, "R8 line0 status after reset");
    check({24'b0, msi_irq}, 32'h0, "R6 msi_irq after reset");

    // R5 enable every group
    for (int g = 0; g < 8; g++) wr(12'(32'h108 + 16*g), 32'hF);
    rd(12'h10C, 32'hF, "R5 group0 enable via clear address");
    rd(12'h17C, 32'hF, "R5 group7 enable via clear address");

    // R1 interleaved vector placement
    msi(8'd0); msi(8'd8); msi(8'd17); msi(8'd31);
    rd(12'h104, 32'h3, "R1 group0 holds vectors 0 and 8");
    rd(12'h114, 32'h4, "R1 group1 holds vector 17");
    rd(12'h174, 32'h8, "R1 group7 holds vector 31");
    rd(12'h124, 32'h0, "R1 group2 empty");
    check({24'b0, msi_irq}, 32'h83, "R6 groups 0,1,7 interrupting");

    // R2 vectors at or above 32
    msi(8'd34); msi(8'd45); msi(8'd200);
    rd(12'h124, 32'h0, "R2 vector 34 ignored");
    rd(12'h154, 32'h0, "R2 vector 45 ignored");
    rd(12'h104, 32'h3, "R2 vector 200 ignored");

    // R3 write-one-to-clear
    wr(12'h104, 32'h1);
    rd(12'h104, 32'h2, "R3 clear bit0 only");

    // R4 arrival wins over same-cycle clear
    msi(8'd9);
    rd(12'h114, 32'h6, "R1 vector 9 in group1 bit1");
    wr_msi(12'h114, 32'h2, 8'd9);
    rd(12'h114, 32'h6, "R4 bit kept on collision");
    wr(12'h114, 32'h2);
    rd(12'h114, 32'h4, "R3 bit cleared without collision");

    // R7 end of interrupt for group1
    wr(EOI, 32'd5);
    idle();
    @(negedge clk);
    check({24'b0, msi_irq}, 32'h81, "R7 group1 quiet cycle");
    idle();
    @(negedge clk);
    check({24'b0, msi_irq}, 32'h83, "R7 group1 re-asserts");
    wr(12'h174, 32'h8);
    idle();

    // R5/R6 masking keeps status
    wr(12'h10C, 32'h3);
    rd(12'h108, 32'hC, "R5 enable after clearing bits 0,1");
    rd(12'h104, 32'h2, "R5 status kept while masked");
    check({24'b0, msi_irq}, 32'h02, "R6 group0 masked");
    wr(12'h108, 32'h2);
    idle();
    check({24'b0, msi_irq}, 32'h03, "R6 group0 unmasked");

    // R8 legacy lines
    set_lines(4'b0101);
    wr(12'h188, 32'h1); wr(12'h198, 32'h1); wr(12'h1A8, 32'h1);
    rd(12'h184, 32'h1, "R8 line0 status");
    rd(12'h194, 32'h0, "R8 line1 status");
    rd(12'h1A4, 32'h1, "R8 line2 status");
    rd(12'h18C, 32'h1, "R8 line0 enable readback");
    rd(12'h1BC, 32'h0, "R8 line3 enable readback");
    check({28'b0, intx_irq}, 32'h5, "R8 intx_irq pattern 0101");
    set_lines(4'b1111);
    idle();
    check({28'b0, intx_irq}, 32'h7, "R8 line3 gated by enable");
    rd(12'h1B4, 32'h1, "R8 disabled line status follows input");

    // R9 end of interrupt for lines
    wr(EOI, 32'd2);
    idle();
    @(negedge clk);
    check({28'b0, intx_irq}, 32'h3, "R9 line2 quiet cycle");
    idle();
    @(negedge clk);
    check({28'b0, intx_irq}, 32'h7, "R9 line2 re-asserts");
    wr(EOI, 32'd12);
    idle();
    @(negedge clk);
    check({24'b0, msi_irq}, 32'h03, "R9 code 12 leaves msi_irq");
    check({28'b0, intx_irq}, 32'h7, "R9 code 12 leaves intx_irq");
    wr(EOI, 32'hFFFF_FFFF);
    idle();
    @(negedge clk);
    check({24'b0, msi_irq}, 32'h03, "R9 large code leaves msi_irq");

    // R10 unmapped space
    wr(12'h200, 32'hFFFF_FFFF);
    wr(12'h100, 32'hFFFF_FFFF);
    rd(12'h104, 32'h2, "R10 group0 status untouched");
    rd(12'h108, 32'hE, "R10 group0 enable untouched");
    rd(12'h114, 32'h4, "R10 group1 status untouched");
    rd(12'h200, 32'h0, "R10 unmapped read");
    rd(EOI, 32'h0, "R10 end-of-interrupt read");
    idle();
    finish_run();
  end

endmodule